// File: doc/BRIEF.md
# Shared BIOS Memory Decoder with Boot-Protocol Detection

This block sits behind a low-pin-count host bus front end that has already parsed each memory cycle. For every cycle it receives a one-cycle valid strobe with the cycle flavour (plain memory or firmware-hub), the direction, a 32-bit address and, for firmware-hub cycles, a flag saying that the ID field matched. It decides whether a shared memory claims the cycle. It reports the claim, which window was hit, and the address translated into the shared memory's space.

There are two kinds of window. The BIOS windows are the legacy F segment, the optional extended E segment and the top 2 MB of the address space. The other is a user window, set by a base and a power-of-two size code. A small configuration register holds the enable bits. After a reset with the BIOS strap active, both bus flavours are enabled. The first BIOS read that is claimed then settles which flavour stays enabled: hardware clears the enable bit of the other flavour, once per reset. After that, software may set either bit again.

Top module: `bios_share_dec`

## Requirements
- R1: The register `cfg_rdata_o` has this layout: bit 0 is the plain-memory BIOS enable, bit 1 the extended-segment enable, bit 2 the user-window enable, bit 3 the firmware-hub BIOS enable, and bit 7 the read-only detect-done flag. Bits 6:4 read 0. Reset loads bits 0 and 3 from `strap_bios_i` and clears bits 1, 2 and 7. During reset, `claim_o` is 0, `region_o` is 0 and `xlat_o` is 0.
- R2: Plain memory reads and writes are claimed when bit 0 is set, in two ranges. Addresses 0x000F0000..0x000FFFFF are claimed as legacy (region 1), with xlat = 0xFFFF0000 | addr[15:0]. Addresses 0xFFE00000..0xFFFFFFFF are claimed as high (region 3), with xlat = addr.
- R3: Plain memory cycles to 0x000E0000..0x000EFFFF are claimed as extended (region 2) only when both bit 0 and bit 1 are set, with xlat = 0xFFFE0000 | addr[15:0].
- R4: A firmware-hub cycle is claimed as high (region 3) only when bit 3 is set and the ID-match flag is high. Only addr[20:0] is used, and xlat = 0xFFE00000 | addr[20:0].
- R5: If the first claimed BIOS read after reset is a plain memory read, bit 3 is cleared and bit 7 is set.
- R6: If the first claimed BIOS read after reset is a firmware-hub read, bit 0 is cleared and bit 7 is set.
- R7: Writes and unclaimed reads do not start detection. The enable bits and bit 7 keep their values.
- R8: Once bit 7 is set, further BIOS reads never clear an enable bit. Software may set either bit again.
- R9: A configuration write in the same cycle as the detecting read takes priority over the hardware clear. Bit 7 is still set in that cycle.
- R10: The user window claims plain memory cycles as user (region 4) when bit 2 is set and addr[31:k] equals base[31:k], where k is the size code (a block of 2^k bytes). Its xlat has bits 31:k forced to 1 and addr[k-1:0] kept.
- R11: A size code below 12 or above 24 disables the user window.
- R12: A cycle that hits both a BIOS window and the user window is reported as the BIOS region.
- R13: The results are registered. `claim_o`, `region_o` and `xlat_o` describe the cycle presented on the previous clock. When valid was low, or the cycle was not claimed, they read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| strap_bios_i | input | 1 | BIOS strap, sampled during reset |
| cyc_valid_i | input | 1 | Parsed cycle strobe |
| cyc_fwh_i | input | 1 | 1 = firmware-hub cycle, 0 = plain memory |
| cyc_write_i | input | 1 | 1 = write, 0 = read |
| cyc_addr_i | input | 32 | Cycle address |
| cyc_id_match_i | input | 1 | Firmware-hub ID field matched |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 4 | New values for bits 3:0 of the configuration register |
| win_base_i | input | 32 | User window base |
| win_size_i | input | 5 | User window size code k (2^k bytes) |
| cfg_rdata_o | output | 8 | Configuration register readback |
| claim_o | output | 1 | Cycle claimed |
| region_o | output | 3 | 0 none, 1 legacy, 2 extended, 3 high, 4 user |
| xlat_o | output | 32 | Translated address |

## Verification
A cycle or a configuration write is driven on a falling edge. Its claim, region and translated address appear at the next rising edge. Any enable or detect-done change caused by that cycle is also visible in `cfg_rdata_o` after the same edge. The bench therefore compares all four outputs against a behavioural model a quarter period after each rising edge. The model computes its expected values from the state held before the edge, and only then updates its own enable bits.

// File: rtl/bsd_pkg.sv
package bsd_pkg;
  typedef enum logic [2:0] {
    REG_NONE   = 3'd0,
    REG_LEGACY = 3'd1,
    REG_EXT    = 3'd2,
    REG_HIGH   = 3'd3,
    REG_USER   = 3'd4
  } region_e;

  localparam int CFG_MEM_BIT  = 0;
  localparam int CFG_EXT_BIT  = 1;
  localparam int CFG_USR_BIT  = 2;
  localparam int CFG_FWH_BIT  = 3;
  localparam int CFG_DONE_BIT = 7;
endpackage

// File: rtl/bsd_cfg.sv
module bsd_cfg (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       strap_i,
  input  logic       we_i,
  input  logic [3:0] wdata_i,
  input  logic       det_rd_i,
  input  logic       det_fwh_i,
  output logic       mem_en_o,
  output logic       ext_en_o,
  output logic       usr_en_o,
  output logic       fwh_en_o,
  output logic       done_o
);
  import bsd_pkg::*;

  logic mem_en_q, ext_en_q, usr_en_q, fwh_en_q, done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_en_q <= strap_i;
      fwh_en_q <= strap_i;
      ext_en_q <= 1'b0;
      usr_en_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      if (we_i) begin
        // software write overrides hardware clear
        mem_en_q <= wdata_i[CFG_MEM_BIT];
        ext_en_q <= wdata_i[CFG_EXT_BIT];
        usr_en_q <= wdata_i[CFG_USR_BIT];
        fwh_en_q <= wdata_i[CFG_FWH_BIT];
      end else if (det_rd_i && !done_q) begin
        if (det_fwh_i) mem_en_q <= 1'b0;
        else           fwh_en_q <= 1'b0;
      end
      if (det_rd_i) done_q <= 1'b1;
    end
  end

  assign mem_en_o = mem_en_q;
  assign ext_en_o = ext_en_q;
  assign usr_en_o = usr_en_q;
  assign fwh_en_o = fwh_en_q;
  assign done_o   = done_q;

  assert_done_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> done_q);
  assert_no_clear_after_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && !we_i) |=> ($stable(mem_en_q) && $stable(fwh_en_q)));
  assert_mem_detect_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!done_q && det_rd_i && !det_fwh_i && !we_i) |=> (!fwh_en_q && done_q));
  assert_fwh_detect_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!done_q && det_rd_i && det_fwh_i && !we_i) |=> (!mem_en_q && done_q));
  assert_write_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (mem_en_q == $past(wdata_i[CFG_MEM_BIT]) && fwh_en_q == $past(wdata_i[CFG_FWH_BIT])));
endmodule

// File: rtl/bsd_bios_match.sv
module bsd_bios_match #(
  parameter int AW       = 32,
  parameter int HIGH_LSB = 21,
  parameter int SEG_LSB  = 16
) (
  input  logic              fwh_i,
  input  logic [AW-1:0]     addr_i,
  input  logic              id_match_i,
  input  logic              mem_en_i,
  input  logic              ext_en_i,
  input  logic              fwh_en_i,
  output logic              hit_o,
  output bsd_pkg::region_e  region_o,
  output logic [AW-1:0]     xlat_o
);
  import bsd_pkg::*;

  localparam int SEGW = AW - SEG_LSB;
  localparam logic [SEGW-1:0] SEG_F = SEGW'(4'hF);
  localparam logic [SEGW-1:0] SEG_E = SEGW'(4'hE);

  logic in_high, in_f, in_e;
  assign in_high = &addr_i[AW-1:HIGH_LSB];
  assign in_f    = addr_i[AW-1:SEG_LSB] == SEG_F;
  assign in_e    = addr_i[AW-1:SEG_LSB] == SEG_E;

  always_comb begin
    hit_o    = 1'b0;
    region_o = REG_NONE;
    xlat_o   = '0;
    if (fwh_i) begin
      if (fwh_en_i && id_match_i) begin
        hit_o    = 1'b1;
        region_o = REG_HIGH;
        xlat_o   = {{(AW-HIGH_LSB){1'b1}}, addr_i[HIGH_LSB-1:0]};
      end
    end else if (mem_en_i) begin
      if (in_f) begin
        hit_o    = 1'b1;
        region_o = REG_LEGACY;
        xlat_o   = {{(AW-SEG_LSB){1'b1}}, addr_i[SEG_LSB-1:0]};
      end else if (in_e && ext_en_i) begin
        hit_o    = 1'b1;
        region_o = REG_EXT;
        xlat_o   = {{(AW-SEG_LSB-1){1'b1}}, 1'b0, addr_i[SEG_LSB-1:0]};
      end else if (in_high) begin
        hit_o    = 1'b1;
        region_o = REG_HIGH;
        xlat_o   = addr_i;
      end
    end
  end
endmodule

// File: rtl/bsd_user_match.sv
module bsd_user_match #(
  parameter int AW     = 32,
  parameter int SZW    = 5,
  parameter int SZ_MIN = 12,
  parameter int SZ_MAX = 24
) (
  input  logic [AW-1:0]  addr_i,
  input  logic [AW-1:0]  base_i,
  input  logic [SZW-1:0] size_i,
  input  logic           en_i,
  output logic           hit_o,
  output logic [AW-1:0]  xlat_o
);
  logic [AW-1:0] low_mask;
  logic          size_ok;

  generate
    if (SZ_MAX >= AW) begin : g_clip
      // a block spanning the whole space needs no upper compare
      assign size_ok = (32'(size_i) >= SZ_MIN) && (32'(size_i) < AW);
    end else begin : g_norm
      assign size_ok = (32'(size_i) >= SZ_MIN) && (32'(size_i) <= SZ_MAX);
    end
  endgenerate

  assign low_mask = (AW'(1) << size_i) - AW'(1);
  assign hit_o    = en_i && size_ok && ((addr_i & ~low_mask) == (base_i & ~low_mask));
  assign xlat_o   = addr_i | ~low_mask;
endmodule

// File: rtl/bios_share_dec.sv
module bios_share_dec #(
  parameter int AW     = 32,
  parameter int SZW    = 5,
  parameter int SZ_MIN = 12,
  parameter int SZ_MAX = 24
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           strap_bios_i,
  input  logic           cyc_valid_i,
  input  logic           cyc_fwh_i,
  input  logic           cyc_write_i,
  input  logic [AW-1:0]  cyc_addr_i,
  input  logic           cyc_id_match_i,
  input  logic           cfg_we_i,
  input  logic [3:0]     cfg_wdata_i,
  input  logic [AW-1:0]  win_base_i,
  input  logic [SZW-1:0] win_size_i,
  output logic [7:0]     cfg_rdata_o,
  output logic           claim_o,
  output logic [2:0]     region_o,
  output logic [AW-1:0]  xlat_o
);
  import bsd_pkg::*;

  logic mem_en, ext_en, usr_en, fwh_en, done;
  logic bios_hit, usr_hit, det_rd, any_hit;
  region_e bios_region, sel_region;
  logic [AW-1:0] bios_xlat, usr_xlat, sel_xlat;

  logic          claim_q;
  region_e       region_q;
  logic [AW-1:0] xlat_q;

  bsd_bios_match #(.AW(AW)) u_bios (
    .fwh_i      (cyc_fwh_i),
    .addr_i     (cyc_addr_i),
    .id_match_i (cyc_id_match_i),
    .mem_en_i   (mem_en),
    .ext_en_i   (ext_en),
    .fwh_en_i   (fwh_en),
    .hit_o      (bios_hit),
    .region_o   (bios_region),
    .xlat_o     (bios_xlat)
  );

  bsd_user_match #(.AW(AW), .SZW(SZW), .SZ_MIN(SZ_MIN), .SZ_MAX(SZ_MAX)) u_user (
    .addr_i (cyc_addr_i),
    .base_i (win_base_i),
    .size_i (win_size_i),
    .en_i   (usr_en && !cyc_fwh_i),
    .hit_o  (usr_hit),
    .xlat_o (usr_xlat)
  );

  assign det_rd = cyc_valid_i && !cyc_write_i && bios_hit;

  bsd_cfg u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .strap_i   (strap_bios_i),
    .we_i      (cfg_we_i),
    .wdata_i   (cfg_wdata_i),
    .det_rd_i  (det_rd),
    .det_fwh_i (cyc_fwh_i),
    .mem_en_o  (mem_en),
    .ext_en_o  (ext_en),
    .usr_en_o  (usr_en),
    .fwh_en_o  (fwh_en),
    .done_o    (done)
  );

  // BIOS windows take priority over the user window
  always_comb begin
    any_hit    = bios_hit || usr_hit;
    sel_region = REG_NONE;
    sel_xlat   = '0;
    if (bios_hit) begin
      sel_region = bios_region;
      sel_xlat   = bios_xlat;
    end else if (usr_hit) begin
      sel_region = REG_USER;
      sel_xlat   = usr_xlat;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      claim_q  <= 1'b0;
      region_q <= REG_NONE;
      xlat_q   <= '0;
    end else if (cyc_valid_i && any_hit) begin
      claim_q  <= 1'b1;
      region_q <= sel_region;
      xlat_q   <= sel_xlat;
    end else begin
      claim_q  <= 1'b0;
      region_q <= REG_NONE;
      xlat_q   <= '0;
    end
  end

  assign claim_o     = claim_q;
  assign region_o    = region_q;
  assign xlat_o      = xlat_q;
  assign cfg_rdata_o = {done, 3'b000, fwh_en, usr_en, ext_en, mem_en};

  assert_idle_quiet_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cyc_valid_i |=> (!claim_o && region_o == 3'd0 && xlat_o == '0));
  assert_claim_tagged_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    claim_o == (region_o != 3'd0));
  assert_high_xlat_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (region_o == 3'd3) |-> (&xlat_o[AW-1:21]));
  assert_fwh_needs_id_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_valid_i && cyc_fwh_i && !cyc_id_match_i) |=> !claim_o);
  assert_bios_over_user_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_valid_i && bios_hit) |=> (region_o != 3'd4));
endmodule

// File: tb/bios_share_dec_tb_top.sv
module bios_share_dec_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        strap = 1'b0;
  logic        v = 1'b0, fwh = 1'b0, wr = 1'b0, idm = 1'b0;
  logic [31:0] addr = '0;
  logic        we = 1'b0;
  logic [3:0]  wd = '0;
  logic [31:0] base = '0;
  logic [4:0]  size = 5'd12;
  logic [7:0]  cfg_rd;
  logic        claim;
  logic [2:0]  region;
  logic [31:0] xlat;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // model state
  bit m_mem, m_ext, m_usr, m_fwh, m_done;
  bit e_claim;
  int e_region;
  longint e_xlat;

  always #(CLK_PERIOD/2) clk = ~clk;

  bios_share_dec dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .strap_bios_i(strap),
    .cyc_valid_i(v), .cyc_fwh_i(fwh), .cyc_write_i(wr), .cyc_addr_i(addr),
    .cyc_id_match_i(idm), .cfg_we_i(we), .cfg_wdata_i(wd),
    .win_base_i(base), .win_size_i(size),
    .cfg_rdata_o(cfg_rd), .claim_o(claim), .region_o(region), .xlat_o(xlat)
  );

  function automatic int model_cfg();
    return (m_done ? 128 : 0) + (m_fwh ? 8 : 0) + (m_usr ? 4 : 0) + (m_ext ? 2 : 0) + (m_mem ? 1 : 0);
  endfunction

  task automatic check(input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  // expected outputs from pre-edge model state
  task automatic predict(input bit pv, input bit pf, input bit pidm, input longint a);
    longint blk, bal;
    bit bios;
    e_claim = 0; e_region = 0; e_xlat = 0; bios = 0;
    if (pv) begin
      if (pf) begin
        if (m_fwh && pidm) begin
          bios = 1; e_region = 3; e_xlat = 64'hFFE00000 + (a % 2097152);
        end
      end else if (m_mem && a >= 64'h000F0000 && a <= 64'h000FFFFF) begin
        bios = 1; e_region = 1; e_xlat = 64'hFFFF0000 + (a % 65536);
      end else if (m_mem && m_ext && a >= 64'h000E0000 && a <= 64'h000EFFFF) begin
        bios = 1; e_region = 2; e_xlat = 64'hFFFE0000 + (a % 65536);
      end else if (m_mem && a >= 64'hFFE00000) begin
        bios = 1; e_region = 3; e_xlat = a;
      end
      if (!bios && !pf && m_usr && size >= 12 && size <= 24) begin
        blk = 64'd1 << size;
        bal = base - (base % blk);
        if (a >= bal && a < bal + blk) begin
          e_region = 4; e_xlat = 64'h100000000 - blk + (a % blk);
        end
      end
      e_claim = (e_region != 0);
    end
  endtask

  task automatic step(input string tag, input bit pv, input bit pf, input bit pwr,
                      input bit pidm, input logic [31:0] a, input bit pwe, input logic [3:0] pwd);
    bit det;
    @(negedge clk);
    v = pv; fwh = pf; wr = pwr; idm = pidm; addr = a; we = pwe; wd = pwd;
    predict(pv, pf, pidm, longint'(a));
    det = pv && !pwr && (e_region inside {1, 2, 3});
    @(posedge clk);
    #(CLK_PERIOD/4);
    if (pwe) begin
      m_mem = pwd[0]; m_ext = pwd[1]; m_usr = pwd[2]; m_fwh = pwd[3];
    end else if (det && !m_done) begin
      if (pf) m_mem = 0; else m_fwh = 0;
    end
    if (det) m_done = 1;
    check(tag, "claim", longint'(claim), longint'(e_claim));
    check(tag, "region", longint'(region), longint'(e_region));
    check(tag, "xlat", longint'(xlat), e_xlat);
    check(tag, "cfg", longint'(cfg_rd), longint'(model_cfg()));
    v = 0; we = 0;
  endtask

  task automatic do_reset(input bit s);
    @(negedge clk);
    strap = s; rst_ni = 0; v = 0; we = 0;
    #(CLK_PERIOD*2);
    m_mem = s; m_fwh = s; m_ext = 0; m_usr = 0; m_done = 0;
    check("R1", "cfg in reset", longint'(cfg_rd), longint'(model_cfg()));
    check("R1", "claim in reset", longint'(claim), 0);
    check("R1", "xlat in reset", longint'(xlat), 0);
    @(negedge clk);
    rst_ni = 1;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD*100000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // strap inactive: nothing claimed
    do_reset(0);
    step("R2", 1, 0, 0, 0, 32'h000F1234, 0, 4'h0);
    step("R13", 0, 0, 0, 0, 32'h000F1234, 0, 4'h0);

    // plain memory detection path
    do_reset(1);
    step("R7", 1, 0, 1, 0, 32'h000F0040, 0, 4'h0);   // write claimed, no detect
    step("R7", 1, 1, 0, 0, 32'hFFFF0000, 0, 4'h0);   // fwh without id match
    step("R4", 1, 1, 0, 0, 32'h00000000, 0, 4'h0);
    step("R5", 1, 0, 0, 0, 32'hFFE01234, 0, 4'h0);   // detecting read
    step("R5", 1, 1, 0, 1, 32'h00001000, 0, 4'h0);   // fwh now off
    step("R8", 0, 0, 0, 0, 32'h0, 1, 4'b1011);        // sw re-enables fwh, ext
    step("R8", 1, 1, 0, 1, 32'h001ABCDE, 0, 4'h0);
    step("R8", 1, 0, 0, 0, 32'h000FFFFF, 0, 4'h0);
    step("R3", 1, 0, 0, 0, 32'h000E1234, 0, 4'h0);
    step("R3", 0, 0, 0, 0, 32'h0, 1, 4'b1001);
    step("R3", 1, 0, 0, 0, 32'h000EFFF0, 0, 4'h0);
    step("R2", 1, 0, 1, 0, 32'hFFFFFFFF, 0, 4'h0);
    step("R2", 1, 0, 0, 0, 32'hFFDFFFFF, 0, 4'h0);
    step("R13", 0, 0, 0, 0, 32'hFFE00000, 0, 4'h0);

    // firmware-hub detection path
    do_reset(1);
    step("R7", 1, 0, 0, 0, 32'h12345678, 0, 4'h0);   // unclaimed read
    step("R6", 1, 1, 0, 1, 32'h00012345, 0, 4'h0);
    step("R6", 1, 0, 0, 0, 32'h000F8000, 0, 4'h0);
    step("R6", 1, 0, 0, 0, 32'hFFF00000, 0, 4'h0);

    // write in the same cycle as detection
    do_reset(1);
    step("R9", 1, 0, 0, 0, 32'h000F0000, 1, 4'b1001);
    step("R9", 1, 1, 0, 1, 32'h00100000, 0, 4'h0);

    // user window
    do_reset(0);
    base = 32'h20003000; size = 5'd12;
    step("R10", 1, 0, 0, 0, 32'h20003ABC, 0, 4'h0);  // disabled
    step("R10", 0, 0, 0, 0, 32'h0, 1, 4'b0100);
    step("R10", 1, 0, 0, 0, 32'h20003ABC, 0, 4'h0);
    step("R10", 1, 0, 1, 0, 32'h20004000, 0, 4'h0);
    step("R10", 1, 1, 0, 1, 32'h20003000, 0, 4'h0);  // fwh never user
    base = 32'h400ABCDE; size = 5'd20;
    step("R10", 1, 0, 0, 0, 32'h400F0010, 0, 4'h0);
    step("R10", 1, 0, 0, 0, 32'h40100000, 0, 4'h0);
    size = 5'd24;
    step("R11", 1, 0, 0, 0, 32'h40FFFFFF, 0, 4'h0);
    size = 5'd25;
    step("R11", 1, 0, 0, 0, 32'h400F0010, 0, 4'h0);
    base = 32'h20003000; size = 5'd11;
    step("R11", 1, 0, 0, 0, 32'h20003010, 0, 4'h0);
    size = 5'd31;
    step("R11", 1, 0, 0, 0, 32'h20003010, 0, 4'h0);

    // overlap: BIOS wins
    base = 32'hFFE00000; size = 5'd21;
    step("R12", 0, 0, 0, 0, 32'h0, 1, 4'b0101);
    step("R12", 1, 0, 1, 0, 32'hFFE00010, 0, 4'h0);
    base = 32'h000F0000; size = 5'd16;
    step("R12", 1, 0, 0, 0, 32'h000F4444, 0, 4'h0);
    step("R12", 0, 0, 0, 0, 32'h0, 1, 4'b0100);
    step("R12", 1, 0, 0, 0, 32'h000F4444, 0, 4'h0);
    step("R13", 0, 0, 0, 0, 32'h000F4444, 0, 4'h0);

    finish_run();
  end
endmodule